// File: doc/BRIEF.md
# NAND Page Register and Cell Array Back End

This block is the storage side of a small-page NAND flash model. It holds one page register, sized for a page's main bytes plus its spare bytes, and a small on-chip cell array. A separate command sequencer opens a read or program session with a page number, a column and a column offset. The block then serves byte-wide data reads and program-data writes that arrive from the pin side.

On the first data read of a read session, the block copies the page into the page register from the start column onward and then streams it out. During a program session, incoming bytes fill the register up to its capacity. A commit request writes them back to the array. An erase request wipes one aligned block of pages to all-ones. Program and erase each end with a one-cycle completion pulse.

After reset, the block sweeps the whole array to 0xFF and reports itself busy until the sweep is complete. Requests that name a page outside the array are dropped.

Top module: `nand_page_buffer`

## Requirements
- R1: After reset, `busy` is 1 while every array byte is set to 0xFF. Once `busy` falls, any byte read from a page that has never been programmed returns 0xFF.
- R2: A page holds PAGE_BYTES main bytes plus PAGE_BYTES/32 spare bytes; the spare bytes sit at columns PAGE_BYTES and up. A read session that starts at column 0 with offset 0 delivers exactly PAGE_BYTES + PAGE_BYTES/32 bytes.
- R3: In a program session, a `wr_strobe` stores `wr_data` only when `ce_n`, `cle` and `ale` are all 0 and fewer than page-plus-spare bytes are already held. Any other write strobe leaves the register unchanged.
- R4: In a read session, the first accepted `rd_strobe` loads the page from start = `req_col` + `req_ofs`. The k-th byte delivered is array byte start+k of that page, and page-plus-spare minus start bytes are available. If start is at or past the page end, no bytes are available.
- R5: Each delivered byte (`rd_valid` = 1 one cycle after it is requested, with the value on `rd_data`) advances the pointer by one. A `rd_strobe` with `ce_n` = 1, or with no bytes remaining, delivers nothing and does not move the pointer.
- R6: `cmd_commit` in a program session writes held byte k to page byte start+k. Bytes that would land past the page end are dropped, and all other array bytes are unchanged. A commit holding zero bytes still pulses `done`.
- R7: `cmd_erase` clears the low ERASE_SHIFT bits of `req_page` to find the block. It sets every main and spare byte of those 2^ERASE_SHIFT pages to 0xFF and leaves other blocks unchanged.
- R8: A load, commit or erase that names a page at or above NUM_BLOCKS*2^ERASE_SHIFT is ignored: no data is delivered, the array is unchanged, and `done` stays 0.
- R9: `busy` is 1 while a load, program or erase is walking the array, and commands presented meanwhile are ignored. `done` is a single-cycle pulse that occurs with `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch phase |
| ale | input | 1 | Address latch phase |
| wr_strobe | input | 1 | Program data byte present |
| wr_data | input | 8 | Program data byte |
| rd_strobe | input | 1 | Data read request |
| rd_data | output | 8 | Delivered read byte |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| req_page | input | PAGE_AW | Page number for a request |
| req_col | input | CW | Start column |
| req_ofs | input | CW | Column offset added to the start column |
| cmd_read | input | 1 | Open a read session |
| cmd_prog | input | 1 | Open a program session and empty the register |
| cmd_commit | input | 1 | Write the held bytes to the array |
| cmd_erase | input | 1 | Erase the block that holds `req_page` |
| busy | output | 1 | Array walk in progress |
| done | output | 1 | One-cycle program or erase completion |

## Verification
Reads are tried from column 0, from a mid-page column, and from the spare area through the offset. A start past the page end is also tried. Together these distinguish a correct start-column sum and remaining-length count from off-by-one and clamping faults. Program data is sent in four forms:
- a stream longer than the register;
- a stream with strobes taken in the command, address and deselected phases;
- a stream committed at a non-zero column;
- an empty stream.

These separate the fill limit, the phase gating and the end-of-page drop. An erase is run against two programmed blocks while a second erase is attempted mid-walk. Out-of-range pages are exercised by all three request kinds, which shows whether block alignment, busy gating and the range guard each act alone.

// File: rtl/nand_pb_pkg.sv
package nand_pb_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOAD,
    ST_PROG,
    ST_WIPE
  } walk_st_e;

  // spare bytes that follow the main area of a page
  function automatic int unsigned spare_of(input int unsigned page_bytes);
    return page_bytes / 32;
  endfunction

  // first column touched by a load or a commit
  function automatic int unsigned start_col(input int unsigned col, input int unsigned ofs);
    return col + ofs;
  endfunction

  // bytes from start to the end of the page (zero past the end)
  function automatic int unsigned span_left(input int unsigned total, input int unsigned start);
    return (start < total) ? total - start : 0;
  endfunction

  // bytes a commit really writes
  function automatic int unsigned commit_span(input int unsigned fill, input int unsigned total,
                                              input int unsigned start);
    int unsigned room;
    room = span_left(total, start);
    return (fill < room) ? fill : room;
  endfunction

  // first page of the erase block that contains page
  function automatic int unsigned block_head(input int unsigned page, input int unsigned es);
    return (page >> es) << es;
  endfunction

endpackage

// File: rtl/nand_pb_ram.sv
module nand_pb_ram #(
  parameter int DEPTH = 66,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nand_pb_ctrl.sv
module nand_pb_ctrl
  import nand_pb_pkg::*;
#(
  parameter int TOTAL     = 66,
  parameter int DEPTH     = 2112,
  parameter int NUM_PAGES = 32,
  parameter int ES        = 4,
  parameter int PAGE_AW   = 6,
  parameter int AW        = 12,
  parameter int CW        = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               cle,
  input  logic               ale,
  input  logic               wr_strobe,
  input  logic [7:0]         wr_data,
  input  logic               rd_strobe,
  input  logic [PAGE_AW-1:0] req_page,
  input  logic [CW-1:0]      req_col,
  input  logic [CW-1:0]      req_ofs,
  input  logic               cmd_read,
  input  logic               cmd_prog,
  input  logic               cmd_commit,
  input  logic               cmd_erase,
  output logic               arr_we,
  output logic [AW-1:0]      arr_waddr,
  output logic [7:0]         arr_wdata,
  output logic [AW-1:0]      arr_raddr,
  input  logic [7:0]         arr_rdata,
  output logic               buf_we,
  output logic [CW-1:0]      buf_waddr,
  output logic [7:0]         buf_wdata,
  output logic [CW-1:0]      buf_raddr,
  input  logic [7:0]         buf_rdata,
  output logic [7:0]         rd_data,
  output logic               rd_valid,
  output logic               busy,
  output logic               done,
  output logic               wiping,
  output logic [CW-1:0]      fill_lvl,
  output logic [CW-1:0]      rem_lvl
);
  localparam int WW = AW + 1;
  localparam logic [CW-1:0] TOT_C = CW'(TOTAL);

  walk_st_e           st;
  logic [WW-1:0]      w_idx, w_lim, w_base, w_addr;
  logic               w_last;
  logic [PAGE_AW-1:0] page_q;
  logic [CW:0]        start_q, req_start;
  logic               mode_rd, mode_pg, loaded, pend;
  logic [CW-1:0]      fill, rem, ptr;
  logic               rd_valid_q, done_q;
  logic [7:0]         rd_data_q;
  logic               idle_free, rd_go, wr_go;
  logic [WW-1:0]      sess_base, c_span, rd_span, wipe_base;

  function automatic logic page_ok(input logic [PAGE_AW-1:0] p);
    return 32'(p) < 32'(NUM_PAGES);
  endfunction

  assign req_start = (CW+1)'(start_col(32'(req_col), 32'(req_ofs)));
  assign sess_base = WW'(32'(page_q) * 32'(TOTAL) + 32'(start_q));
  assign wipe_base = WW'(block_head(32'(req_page), ES) * 32'(TOTAL));
  assign c_span    = WW'(commit_span(32'(fill), TOTAL, 32'(start_q)));
  assign rd_span   = WW'(span_left(TOTAL, 32'(start_q)));

  assign w_addr = w_base + w_idx;
  assign w_last = (w_idx == w_lim - 1'b1);

  assign idle_free = (st == ST_IDLE) && !(cmd_erase || cmd_read || cmd_prog || cmd_commit) && !pend;
  assign rd_go     = idle_free && rd_strobe && !ce_n && mode_rd;
  assign wr_go     = idle_free && !rd_go && wr_strobe && !ce_n && !cle && !ale
                     && mode_pg && (fill < TOT_C);

  // array port: wipe and program write, load reads
  assign arr_we    = (st == ST_INIT) || (st == ST_WIPE) || (st == ST_PROG);
  assign arr_waddr = AW'(w_addr);
  assign arr_wdata = (st == ST_PROG) ? buf_rdata : 8'hFF;
  assign arr_raddr = AW'(w_addr);

  // page register port
  assign buf_we    = (st == ST_LOAD) || wr_go;
  assign buf_waddr = (st == ST_LOAD) ? CW'(w_idx) : fill;
  assign buf_wdata = (st == ST_LOAD) ? arr_rdata : wr_data;
  assign buf_raddr = (st == ST_PROG) ? CW'(w_idx) : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_INIT;
      w_idx      <= '0;
      w_lim      <= WW'(DEPTH);
      w_base     <= '0;
      page_q     <= '0;
      start_q    <= '0;
      mode_rd    <= 1'b0;
      mode_pg    <= 1'b0;
      loaded     <= 1'b0;
      pend       <= 1'b0;
      fill       <= '0;
      rem        <= '0;
      ptr        <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      done_q     <= 1'b0;
      unique case (st)
        ST_INIT, ST_WIPE, ST_PROG: begin
          w_idx <= w_idx + 1'b1;
          if (w_last) begin
            st     <= ST_IDLE;
            done_q <= (st != ST_INIT);
          end
        end
        ST_LOAD: begin
          w_idx <= w_idx + 1'b1;
          if (w_last) begin
            st     <= ST_IDLE;
            loaded <= 1'b1;
            rem    <= CW'(w_lim);
            ptr    <= '0;
            pend   <= 1'b1;
          end
        end
        ST_IDLE: begin
          if (cmd_erase) begin
            if (page_ok(req_page)) begin
              st     <= ST_WIPE;
              w_idx  <= '0;
              w_base <= wipe_base;
              w_lim  <= WW'((1 << ES) * TOTAL);
            end
          end else if (cmd_read) begin
            mode_rd <= 1'b1;
            mode_pg <= 1'b0;
            page_q  <= req_page;
            start_q <= req_start;
            loaded  <= 1'b0;
            pend    <= 1'b0;
            rem     <= '0;
            ptr     <= '0;
          end else if (cmd_prog) begin
            mode_pg <= 1'b1;
            mode_rd <= 1'b0;
            page_q  <= req_page;
            start_q <= req_start;
            fill    <= '0;
          end else if (cmd_commit) begin
            mode_pg <= 1'b0;
            if (mode_pg && page_ok(page_q)) begin
              if (c_span != '0) begin
                st     <= ST_PROG;
                w_idx  <= '0;
                w_base <= sess_base;
                w_lim  <= c_span;
              end else begin
                done_q <= 1'b1;
              end
            end
          end else if (pend) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= buf_rdata;
            ptr        <= ptr + 1'b1;
            rem        <= rem - 1'b1;
            pend       <= 1'b0;
          end else if (rd_go) begin
            if (!loaded) begin
              if (page_ok(page_q) && rd_span != '0) begin
                st     <= ST_LOAD;
                w_idx  <= '0;
                w_base <= sess_base;
                w_lim  <= rd_span;
              end else begin
                loaded <= 1'b1;
              end
            end else if (rem != '0) begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= buf_rdata;
              ptr        <= ptr + 1'b1;
              rem        <= rem - 1'b1;
            end
          end else if (wr_go) begin
            fill <= fill + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign done     = done_q;
  assign busy     = (st != ST_IDLE);
  assign wiping   = (st == ST_INIT) || (st == ST_WIPE);
  assign fill_lvl = fill;
  assign rem_lvl  = rem;
endmodule

// File: rtl/nand_page_buffer.sv
module nand_page_buffer
  import nand_pb_pkg::*;
#(
  parameter int PAGE_BYTES  = 64,
  parameter int ERASE_SHIFT = 4,
  parameter int NUM_BLOCKS  = 2,
  parameter int PAGE_AW     = 6,
  localparam int TOTAL      = PAGE_BYTES + int'(spare_of(PAGE_BYTES)),
  localparam int NUM_PAGES  = NUM_BLOCKS << ERASE_SHIFT,
  localparam int DEPTH      = NUM_PAGES * TOTAL,
  localparam int AW         = $clog2(DEPTH),
  localparam int CW         = $clog2(TOTAL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               cle,
  input  logic               ale,
  input  logic               wr_strobe,
  input  logic [7:0]         wr_data,
  input  logic               rd_strobe,
  output logic [7:0]         rd_data,
  output logic               rd_valid,
  input  logic [PAGE_AW-1:0] req_page,
  input  logic [CW-1:0]      req_col,
  input  logic [CW-1:0]      req_ofs,
  input  logic               cmd_read,
  input  logic               cmd_prog,
  input  logic               cmd_commit,
  input  logic               cmd_erase,
  output logic               busy,
  output logic               done
);
  // named internal events for the checker
  logic          arr_we, buf_we, wiping;
  logic [AW-1:0] arr_waddr, arr_raddr;
  logic [7:0]    arr_wdata, arr_rdata, buf_wdata, buf_rdata;
  logic [CW-1:0] buf_waddr, buf_raddr, fill_lvl, rem_lvl;

  nand_pb_ram #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  nand_pb_ram #(.DEPTH(TOTAL), .AW(CW)) u_pagereg (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  nand_pb_ctrl #(
    .TOTAL(TOTAL), .DEPTH(DEPTH), .NUM_PAGES(NUM_PAGES), .ES(ERASE_SHIFT),
    .PAGE_AW(PAGE_AW), .AW(AW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .req_page(req_page), .req_col(req_col), .req_ofs(req_ofs),
    .cmd_read(cmd_read), .cmd_prog(cmd_prog), .cmd_commit(cmd_commit), .cmd_erase(cmd_erase),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .wiping(wiping), .fill_lvl(fill_lvl), .rem_lvl(rem_lvl)
  );
endmodule

// File: rtl/nand_page_buffer_chk.sv
module nand_page_buffer_chk #(
  parameter int TOTAL = 66,
  parameter int DEPTH = 2112,
  parameter int AW    = 12,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          rd_valid,
  input logic          arr_we,
  input logic [AW-1:0] arr_waddr,
  input logic [7:0]    arr_wdata,
  input logic          wiping,
  input logic [CW-1:0] fill_lvl,
  input logic [CW-1:0] rem_lvl
);
  assert_fill_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill_lvl) <= 32'(TOTAL));

  assert_rem_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rem_lvl == $past(rem_lvl) - 1'b1);

  assert_wipe_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && wiping) |-> arr_wdata == 8'hFF);

  assert_write_in_array_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> 32'(arr_waddr) < 32'(DEPTH));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_quiet_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy);
endmodule

bind nand_page_buffer nand_page_buffer_chk #(
  .TOTAL(TOTAL), .DEPTH(DEPTH), .AW(AW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_valid(rd_valid),
  .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
  .wiping(wiping), .fill_lvl(fill_lvl), .rem_lvl(rem_lvl)
);

// File: tb/nand_page_buffer_tb.sv
module nand_page_buffer_tb;
  localparam int PAGE_BYTES  = 64;
  localparam int ERASE_SHIFT = 4;
  localparam int NUM_BLOCKS  = 2;
  localparam int PAGE_AW     = 6;
  localparam int TOTAL       = PAGE_BYTES + PAGE_BYTES / 32;
  localparam int NUM_PAGES   = NUM_BLOCKS << ERASE_SHIFT;
  localparam int DEPTH       = NUM_PAGES * TOTAL;
  localparam int CW          = $clog2(TOTAL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0;
  logic wr_strobe = 1'b0, rd_strobe = 1'b0;
  logic [7:0] wr_data = '0;
  logic [PAGE_AW-1:0] req_page = '0;
  logic [CW-1:0] req_col = '0, req_ofs = '0;
  logic cmd_read = 1'b0, cmd_prog = 1'b0, cmd_commit = 1'b0, cmd_erase = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid, busy, done;

  always #2 clk = ~clk;  // 250 MHz

  nand_page_buffer #(
    .PAGE_BYTES(PAGE_BYTES), .ERASE_SHIFT(ERASE_SHIFT),
    .NUM_BLOCKS(NUM_BLOCKS), .PAGE_AW(PAGE_AW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .rd_valid(rd_valid), .req_page(req_page),
    .req_col(req_col), .req_ofs(req_ofs), .cmd_read(cmd_read), .cmd_prog(cmd_prog),
    .cmd_commit(cmd_commit), .cmd_erase(cmd_erase), .busy(busy), .done(done)
  );

  // scoreboard and reference model
  logic [7:0] q_exp[$];
  string      q_tag[$];
  int n_chk = 0, n_bad = 0, n_valid = 0, cyc = 0;
  bit finished = 1'b0;
  logic [7:0] ref_mem [DEPTH];
  logic [7:0] ref_buf [TOTAL];
  bit m_rd = 0, m_pg = 0, m_loaded = 0;
  int m_page = 0, m_start = 0, m_rem = 0, m_ptr = 0, m_fill = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_valid++;
      if (q_exp.size() == 0) begin
        check(1'b0, "R5", "unexpected rd_valid", int'(rd_data), -1);
      end else begin
        logic [7:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(rd_data == e, t, "read byte", int'(rd_data), int'(e));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      check(1'b0, "R9", "watchdog expired", cyc, 0);
      finish_run();
    end
  end

  task automatic rd_cmd(input int page, input int col, input int ofs);
    @(negedge clk);
    req_page = PAGE_AW'(page); req_col = CW'(col); req_ofs = CW'(ofs); cmd_read = 1'b1;
    @(negedge clk);
    cmd_read = 1'b0;
    m_rd = 1; m_pg = 0; m_loaded = 0; m_page = page; m_start = col + ofs; m_rem = 0; m_ptr = 0;
  endtask

  // driver: one read strobe, expected byte pushed to the scoreboard
  task automatic rd_one(input string tag, input bit ce_high);
    if (!ce_high && m_rd) begin
      if (!m_loaded) begin
        m_loaded = 1;
        if (m_page < NUM_PAGES && m_start < TOTAL) begin
          m_rem = TOTAL - m_start;
          m_ptr = 0;
        end
      end
      if (m_rem > 0) begin
        q_exp.push_back(ref_mem[m_page * TOTAL + m_start + m_ptr]);
        q_tag.push_back(tag);
        m_ptr++; m_rem--;
      end
    end
    @(negedge clk);
    ce_n = ce_high; rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0; ce_n = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // read a whole session, then one extra strobe that must deliver nothing
  task automatic rd_range(input int page, input int col, input int ofs, input string tag);
    int nv;
    rd_cmd(page, col, ofs);
    rd_one(tag, 1'b0);
    while (m_rem > 0) rd_one(tag, 1'b0);
    nv = n_valid;
    rd_one("R5", 1'b0);
    repeat (2) @(negedge clk);
    check(n_valid == nv, "R5", "read past end delivered data", n_valid - nv, 0);
    check(q_exp.size() == 0, tag, "bytes not delivered", q_exp.size(), 0);
  endtask

  task automatic prog_open(input int page, input int col);
    @(negedge clk);
    req_page = PAGE_AW'(page); req_col = CW'(col); req_ofs = '0; cmd_prog = 1'b1;
    @(negedge clk);
    cmd_prog = 1'b0;
    m_pg = 1; m_rd = 0; m_page = page; m_start = col; m_fill = 0;
  endtask

  task automatic wr_one(input logic [7:0] b, input bit c, input bit a, input bit ce_high);
    if (m_pg && !c && !a && !ce_high && m_fill < TOTAL) begin
      ref_buf[m_fill] = b;
      m_fill++;
    end
    @(negedge clk);
    wr_data = b; cle = c; ale = a; ce_n = ce_high; wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic wait_done(input bit expect_it, input int lim, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < lim && !seen; k++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    check(seen == expect_it, tag, "done pulse presence", int'(seen), int'(expect_it));
    if (seen) begin
      @(negedge clk);
      check(done == 1'b0, "R9", "done wider than one cycle", int'(done), 0);
    end
  endtask

  task automatic commit(input string tag);
    bit ok;
    ok = m_pg && (m_page < NUM_PAGES);
    if (ok) begin
      for (int k = 0; k < m_fill; k++)
        if (m_start + k < TOTAL) ref_mem[m_page * TOTAL + m_start + k] = ref_buf[k];
    end
    m_pg = 0;
    @(negedge clk);
    cmd_commit = 1'b1;
    @(negedge clk);
    cmd_commit = 1'b0;
    wait_done(ok, ok ? 400 : 100, tag);
  endtask

  task automatic wipe_model(input int page);
    int head;
    head = (page >> ERASE_SHIFT) << ERASE_SHIFT;
    if (page < NUM_PAGES)
      for (int k = 0; k < (TOTAL << ERASE_SHIFT); k++) ref_mem[head * TOTAL + k] = 8'hFF;
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R1", "busy during power-up wipe", int'(busy), 1);
    begin
      int w = 0;
      while (busy && w < 5000) begin @(negedge clk); w++; end
      check(busy == 1'b0, "R1", "power-up wipe did not finish", int'(busy), 0);
    end

    // R1 / R2: erased pages read as all-ones, full page length
    rd_range(0, 0, 0, "R1");
    rd_range(NUM_PAGES - 1, 0, 0, "R2");

    // R3: overlong stream with strobes in disallowed phases
    prog_open(2, 0);
    wr_one(8'hAA, 1'b1, 1'b0, 1'b0);
    wr_one(8'hAB, 1'b0, 1'b1, 1'b0);
    wr_one(8'hAC, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < TOTAL + 4; k++) wr_one(8'(k * 7 + 3), 1'b0, 1'b0, 1'b0);
    commit("R6");
    rd_range(2, 0, 0, "R3");

    // R6: commit at a non-zero column, tail dropped at page end
    prog_open(3, 5);
    for (int k = 0; k < TOTAL; k++) wr_one(8'(k) ^ 8'h5A, 1'b0, 1'b0, 1'b0);
    commit("R6");
    rd_range(3, 0, 0, "R6");

    // R4: mid-page start, spare area through the offset, start past end
    rd_range(2, 10, 0, "R4");
    rd_range(2, 0, PAGE_BYTES, "R4");
    rd_range(3, TOTAL, 1, "R4");

    // R5: deselected strobes deliver nothing and keep the pointer
    rd_cmd(3, 20, 0);
    repeat (3) rd_one("R5", 1'b0);
    begin
      int nv;
      nv = n_valid;
      rd_one("R5", 1'b1);
      rd_one("R5", 1'b1);
      repeat (2) @(negedge clk);
      check(n_valid == nv, "R5", "deselected read delivered data", n_valid - nv, 0);
    end
    while (m_rem > 0) rd_one("R5", 1'b0);
    repeat (2) @(negedge clk);
    check(q_exp.size() == 0, "R5", "bytes not delivered", q_exp.size(), 0);

    // second block content
    prog_open(17, 0);
    for (int k = 0; k < TOTAL; k++) wr_one(8'(255 - k), 1'b0, 1'b0, 1'b0);
    commit("R6");

    // R7 / R9: erase block 0 via page 5; a second erase while busy is dropped
    @(negedge clk);
    req_page = PAGE_AW'(5); cmd_erase = 1'b1;
    @(negedge clk);
    cmd_erase = 1'b0;
    wipe_model(5);
    repeat (10) @(negedge clk);
    check(busy == 1'b1, "R9", "busy during erase", int'(busy), 1);
    req_page = PAGE_AW'(17); cmd_erase = 1'b1;
    @(negedge clk);
    cmd_erase = 1'b0;
    wait_done(1'b1, 3000, "R7");
    rd_range(2, 0, 0, "R7");
    rd_range(3, 0, 0, "R7");
    rd_range(17, 0, 0, "R9");

    // R8: out-of-range page for program, erase and load
    prog_open(40, 0);
    for (int k = 0; k < 5; k++) wr_one(8'h11, 1'b0, 1'b0, 1'b0);
    commit("R8");
    @(negedge clk);
    req_page = PAGE_AW'(40); cmd_erase = 1'b1;
    @(negedge clk);
    cmd_erase = 1'b0;
    wait_done(1'b0, 100, "R8");
    rd_range(40, 0, 0, "R8");
    rd_range(17, 0, 0, "R8");

    // R6: empty commit still completes, array untouched
    prog_open(17, 0);
    commit("R6");
    rd_range(17, 0, 0, "R6");

    finish_run();
  end
endmodule